// File: doc/BRIEF.md
# DDR Output Serializer with Pair Gearbox

This block takes data bits from the core logic and turns them into one serial output bit. It has three modes. In single-rate mode one bit per clock reaches the output, through either an edge-triggered flop or a level-sensitive latch. In double-rate mode two bits are captured on each rising edge and sent out in turn: one while the clock is high, the other while it is low. In gearbox mode four bits are taken in every second clock and sent out over two periods, one bit per half-period.

Double-rate output works like this. Rising-edge flops capture the bits, and a latch holds the low-phase bit stable while it is selected. The clock level steers a two-input multiplexer that picks which stored bit is driven. Gearbox mode adds two shadow flops, which keep the third and fourth streams for the second period, and a phase flop that tracks which half of the two-period frame is running. The shadow flops stand in for the flops that a neighbouring pin of a true/complement pair would lend.

Top module: `ddr_gear_oreg`

## Requirements
- R1: With mode = 2'b00 and sdr_latch = 0, q equals the d_neg0 value sampled at the last enabled rising edge and stays at it through the whole period. A change of d_neg0 after the edge, or any value on d_pos0, d_neg1 or d_pos1, has no effect on q.
- R2: With mode = 2'b00 and sdr_latch = 1, q follows d_neg0 while clk is high and ce is 1. While clk is low, q holds the last value it passed.
- R3: With mode = 2'b01 (2'b11 behaves the same), d_neg0 and d_pos0 are both captured at the rising edge. In the period that follows, q shows the captured d_neg0 while clk is high and the captured d_pos0 while clk is low.
- R4: In double-rate mode, a change on d_pos0 after the rising edge does not alter the bit shown during the low half of that period.
- R5: With mode = 2'b10, the edge that starts a frame loads all four streams. q then shows d_neg0 (first period, high), d_pos0 (first period, low), d_neg1 (second period, high) and d_pos1 (second period, low). The inputs at the second edge of a frame are ignored.
- R6: The first enabled edge in gearbox mode after reset, or after entering gearbox mode from another mode, starts a new frame.
- R7: While ce is 0, every storage element holds its value: the capture flops, the shadow flops, the frame phase and the single-rate flop and latch.
- R8: While rst_n is 0, q is 0 at once. A rising edge with rst_n at 0 clears all storage, including the frame phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its level also selects the output half-bit |
| rst_n | input | 1 | Synchronous active-low reset; forces q to 0 while low |
| ce | input | 1 | Clock enable; 0 holds all storage |
| mode | input | 2 | 00 single rate, 01/11 double rate, 10 gearbox |
| sdr_latch | input | 1 | Single-rate storage: 0 flop, 1 latch |
| d_neg0 | input | 1 | Stream 0: single-rate bit, high-phase bit |
| d_pos0 | input | 1 | Stream 1: low-phase bit |
| d_neg1 | input | 1 | Stream 2: gearbox second-period high bit |
| d_pos1 | input | 1 | Stream 3: gearbox second-period low bit |
| q | output | 1 | Serial output bit |

## Verification
The hardest case to reach from the ports is an input that changes in the middle of a clock phase. Only then can the bench tell a transparent latch from a held one, or a captured bit from a live input. The bench drives such mid-phase changes at fixed offsets after the edge and samples q a few nanoseconds later. The second, input-ignoring edge of a gearbox frame, and a reset that lands in mid-frame, are reached by walking an exact sequence of cycles from a known phase.

// File: rtl/ddrg_pkg.sv
// Package ddrg_pkg: shared mode encoding for the DDR output serializer.
// Assumes a 2-bit mode field at the top-level port.
package ddrg_pkg;
    localparam int MODE_W = 2;
    typedef enum logic [MODE_W-1:0] {
        M_SDR     = 2'b00,
        M_DDR     = 2'b01,
        M_GEAR    = 2'b10,
        M_DDR_ALT = 2'b11
    } mode_e;
endpackage

// File: rtl/ddrg_sdr_stage.sv
// Module ddrg_sdr_stage: single-rate storage element, selectable as a
// rising-edge flop or a latch that is transparent while clk is high.
// Assumes a synchronous active-low reset; ce gates both variants.
module ddrg_sdr_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic latch_sel,
    input  logic d,
    output logic q_o
);
    logic flop_q;
    logic lat_q;

    // Edge-triggered variant: capture d on each enabled rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flop_q <= 1'b0;
        else if (ce)
            flop_q <= d;
    end

    // Level-sensitive variant: pass d while clk is high, hold while low.
    always_latch begin
        if (clk) begin
            if (!rst_n)
                lat_q <= 1'b0;
            else if (ce)
                lat_q <= d;
        end
    end

    // Pick the configured storage variant.
    assign q_o = latch_sel ? lat_q : flop_q;
endmodule

// File: rtl/ddrg_capture.sv
// Module ddrg_capture: rising-edge capture of the high-phase and low-phase
// bits, with two shadow flops and a frame-phase flop for gearbox mode.
// Assumes: gear_en stable around edges; phase 0 means the next edge loads.
module ddrg_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic gear_en,
    input  logic n0,
    input  logic p0,
    input  logic n1,
    input  logic p1,
    output logic hi_bit,
    output logic lo_bit
);
    logic sh_hi;
    logic sh_lo;
    logic frame_ph;

    // Load new streams, or replay the shadowed pair in the second gearbox period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_bit   <= 1'b0;
            lo_bit   <= 1'b0;
            sh_hi    <= 1'b0;
            sh_lo    <= 1'b0;
            frame_ph <= 1'b0;
        end else if (ce) begin
            if (gear_en && frame_ph) begin
                hi_bit   <= sh_hi;
                lo_bit   <= sh_lo;
                frame_ph <= 1'b0;
            end else begin
                hi_bit <= n0;
                lo_bit <= p0;
                if (gear_en) begin
                    sh_hi    <= n1;
                    sh_lo    <= p1;
                    frame_ph <= 1'b1;
                end else begin
                    frame_ph <= 1'b0;
                end
            end
        end
    end

    // R5
    ph_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && gear_en) |=> (frame_ph != $past(frame_ph)));

    // R7
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(hi_bit) && $stable(lo_bit) && $stable(sh_hi)
                 && $stable(sh_lo) && $stable(frame_ph)));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!frame_ph && !hi_bit && !lo_bit));
endmodule

// File: rtl/ddrg_phase_mux.sv
// Module ddrg_phase_mux: holds the low-phase bit in a latch that is open while
// clk is high, then lets the clock level pick the driven bit.
// Assumes hi_bit/lo_bit change only at rising edges.
module ddrg_phase_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_bit,
    input  logic lo_bit,
    output logic ddr_q
);
    logic lo_held;

    // Keep the low-phase bit steady across the whole low half-period.
    always_latch begin
        if (clk)
            lo_held <= lo_bit;
    end

    // Drive the high-phase bit while clk is high, the held bit while low.
    assign ddr_q = clk ? hi_bit : lo_held;

    // R4
    latch_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_held == lo_bit);
endmodule

// File: rtl/ddr_gear_oreg.sv
// Module ddr_gear_oreg: output register block that serializes core data
// onto one bit at single rate, double rate or four-stream gearbox rate.
// Assumes a synchronous active-low reset; q is forced low during reset.
module ddr_gear_oreg
    import ddrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [MODE_W-1:0] mode,
    input  logic              sdr_latch,
    input  logic              d_neg0,
    input  logic              d_pos0,
    input  logic              d_neg1,
    input  logic              d_pos1,
    output logic              q
);
    mode_e mode_v;
    logic  gear_en;
    logic  sdr_sel;
    logic  sdr_q;
    logic  hi_bit;
    logic  lo_bit;
    logic  ddr_q;

    // Decode the mode field.
    always_comb begin
        mode_v  = mode_e'(mode);
        gear_en = (mode_v == M_GEAR);
        sdr_sel = (mode_v == M_SDR);
    end

    ddrg_sdr_stage u_sdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .latch_sel (sdr_latch),
        .d         (d_neg0),
        .q_o       (sdr_q)
    );

    ddrg_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .gear_en (gear_en),
        .n0      (d_neg0),
        .p0      (d_pos0),
        .n1      (d_neg1),
        .p1      (d_pos1),
        .hi_bit  (hi_bit),
        .lo_bit  (lo_bit)
    );

    ddrg_phase_mux u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_bit (hi_bit),
        .lo_bit (lo_bit),
        .ddr_q  (ddr_q)
    );

    // Final output select with reset gating.
    assign q = rst_n & (sdr_sel ? sdr_q : ddr_q);
endmodule

// File: tb/sim_ddr_gear_oreg.sv
// Bench for ddr_gear_oreg: vector table walk, then directed mid-phase tests.
module sim_ddr_gear_oreg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       sdr_latch = 1'b0;
    logic       d_neg0 = 1'b0, d_pos0 = 1'b0, d_neg1 = 1'b0, d_pos1 = 1'b0;
    logic       q;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       hi, lo;

    always #10 clk = ~clk;

    ddr_gear_oreg u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .mode(mode), .sdr_latch(sdr_latch),
        .d_neg0(d_neg0), .d_pos0(d_pos0), .d_neg1(d_neg1), .d_pos1(d_pos1), .q(q)
    );

    // Row layout: [9:8] mode, [7] sdr_latch, [6] ce, [5:2] d_neg0,d_pos0,d_neg1,d_pos1,
    // [1] expected q in high half, [0] expected q in low half.
    localparam logic [9:0] VEC [18] = '{
        10'b00_0_1_1000_11, 10'b00_0_1_0100_00, 10'b00_0_1_1100_11, 10'b00_0_0_0000_11,
        10'b01_0_1_1000_10, 10'b01_0_1_0100_01, 10'b01_0_1_1100_11, 10'b01_0_1_0000_00,
        10'b01_0_0_1100_00, 10'b01_0_1_1000_10,
        10'b10_0_1_1011_10, 10'b10_0_1_0000_11, 10'b10_0_1_0110_01, 10'b10_0_1_1111_10,
        10'b10_0_1_1100_11, 10'b10_0_0_0000_11, 10'b10_0_1_1111_00, 10'b10_0_1_0110_01
    };

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: q=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Called 3 ns before a rising edge; returns q mid-high and mid-low, ends at the same point.
    task automatic step(input logic [1:0] m, input logic l, input logic c,
                        input logic [3:0] d, output logic h, output logic w);
        mode = m; sdr_latch = l; ce = c;
        {d_neg0, d_pos0, d_neg1, d_pos1} = d;
        @(posedge clk);
        #5 h = q;
        #10 w = q;
        #2;
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        string tag;
        @(posedge clk);
        #5 chk(q, 1'b0, "R8 reset state");
        @(posedge clk);
        #17 rst_n = 1'b1;

        for (int i = 0; i < 18; i++) begin
            step(VEC[i][9:8], VEC[i][7], VEC[i][6], VEC[i][5:2], hi, lo);
            if (!VEC[i][6]) tag = "R7 hold";
            else if (VEC[i][9:8] == 2'b00) tag = "R1 single rate";
            else if (VEC[i][9:8] == 2'b01) tag = "R3 double rate";
            else tag = "R5 gearbox";
            chk(hi, VEC[i][1], $sformatf("%s row %0d high", tag, i));
            chk(lo, VEC[i][0], $sformatf("%s row %0d low", tag, i));
        end

        // R2: latch transparency while high, hold while low
        mode = 2'b00; sdr_latch = 1'b1; ce = 1'b1; d_neg0 = 1'b0;
        @(posedge clk);
        #3 d_neg0 = 1'b1;
        #2 chk(q, 1'b1, "R2 transparent high");
        #7 d_neg0 = 1'b0;
        #3 chk(q, 1'b1, "R2 hold low");
        #10 chk(q, 1'b0, "R2 reopen high");
        #1 begin ce = 1'b0; d_neg0 = 1'b1; end
        #2 chk(q, 1'b0, "R7 latch hold");
        @(negedge clk);
        #7 ce = 1'b1;

        // R3/R4: live inputs after the edge must not reach q
        mode = 2'b01; sdr_latch = 1'b0; d_neg0 = 1'b1; d_pos0 = 1'b0;
        @(posedge clk);
        #3 begin d_neg0 = 1'b0; d_pos0 = 1'b1; end
        #2 chk(q, 1'b1, "R3 high bit captured");
        #10 chk(q, 1'b0, "R4 low bit held");
        #2;

        // R1: flop ignores change after edge
        mode = 2'b00; d_neg0 = 1'b1;
        @(posedge clk);
        #3 d_neg0 = 1'b0;
        #2 chk(q, 1'b1, "R1 flop after-edge change");
        #12;

        // R8/R6: reset forcing and frame restart
        rst_n = 1'b0;
        #1 chk(q, 1'b0, "R8 immediate force");
        #0;
        step(2'b01, 1'b0, 1'b1, 4'b1100, hi, lo);
        chk(hi, 1'b0, "R8 reset high"); chk(lo, 1'b0, "R8 reset low");
        rst_n = 1'b1;
        step(2'b10, 1'b0, 1'b1, 4'b1010, hi, lo);
        chk(hi, 1'b1, "R5 frame load high"); chk(lo, 1'b0, "R5 frame load low");
        rst_n = 1'b0;
        step(2'b10, 1'b0, 1'b1, 4'b1111, hi, lo);
        chk(hi, 1'b0, "R8 mid-frame reset high"); chk(lo, 1'b0, "R8 mid-frame reset low");
        rst_n = 1'b1;
        step(2'b10, 1'b0, 1'b1, 4'b0111, hi, lo);
        chk(hi, 1'b0, "R6 restart high"); chk(lo, 1'b1, "R6 restart low");
        step(2'b10, 1'b0, 1'b1, 4'b0000, hi, lo);
        chk(hi, 1'b1, "R5 second period high"); chk(lo, 1'b1, "R5 second period low");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule